// File: doc/BRIEF.md
# I2C Target Address Matcher with General-Call Recognition

This block listens to an I2C bus as a target. It finds START and STOP conditions on the sampled clock and data lines and shifts in the first byte after each START. It compares that byte with a programmed address of its own and, when enabled, with the all-zero general-call address. A match causes four things:
- the byte is copied into a receive register;
- a buffer-full flag is raised;
- the data line is pulled low for the ninth (acknowledge) clock;
- a one-cycle interrupt pulse is given after that clock ends.

In 10-bit mode the first byte carries a fixed prefix and the two upper address bits. A match on it raises an update-address flag and the block then expects the lower eight address bits as a second byte. A general call in 10-bit mode skips that second byte and goes straight to data. After a match, each further byte until STOP or the next START is shifted in, buffered and acknowledged the same way. Software can tell a general call from an own-address match by reading the buffered byte: zero means general call.

SCL and SDA are expected already synchronised to `clk`. The block only pulls SDA low; the pad logic combines `sda_pull_o` with the open-drain line.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the outputs are as follows: `sda_pull_o`, `buf_full_o`, `irq_o`, `upd_addr_o`, `start_seen_o` and `stop_seen_o` are 0, and `bus_free_o` is 1.
- R2: START and STOP are reported as follows:
  - A START (SDA falls while SCL is high) sets `start_seen_o` and clears `stop_seen_o`.
  - A STOP (SDA rises while SCL is high) sets `stop_seen_o` and clears `start_seen_o`.
  - `bus_free_o` is 1 when `stop_seen_o` is set or when neither flag is set.
- R3: In 7-bit mode (`ten_bit_i`=0), an address byte matches when its bits [7:1] equal `own_addr_i[6:0]`, whatever bit 0 (R/W) holds. On a match:
  - the byte is loaded into `rx_byte_o`;
  - `buf_full_o` sets on the eighth SCL rising edge;
  - `sda_pull_o` is 1 from the eighth SCL falling edge to the ninth.
- R4: `irq_o` pulses for exactly one clock after the ninth SCL falling edge of every acknowledged byte, and never while SCL is high.
- R5: A byte that matches nothing gets no acknowledge, no buffer load and no interrupt. Every byte after it is ignored until the next START.
- R6: Byte 0x00 matches as a general call only when `gc_en_i` is 1. Byte 0x01 (a read) is never a general call.
- R7: In 10-bit mode, the two address bytes are handled as follows:
  - First byte `{11110, own_addr_i[9:8], R/W}`: acknowledged, and `upd_addr_o` sets.
  - Second byte equal to `own_addr_i[7:0]`: acknowledged, `upd_addr_o` clears, and the following bytes are data.
  - Any other second byte: not acknowledged, and `upd_addr_o` clears.
- R8: In 10-bit mode with `gc_en_i`=1, a first byte of 0x00 is acknowledged and `upd_addr_o` stays 0. The next byte is taken directly as data.
- R9: After a match, each following byte is loaded into `rx_byte_o`, acknowledged and signalled with `irq_o`.
- R10: A STOP returns the receiver to idle and clears `upd_addr_o`. Bytes clocked after a STOP without a new START are not acknowledged and raise no interrupt.
- R11: A one-cycle `buf_rd_i` clears `buf_full_o` when no new byte lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| own_addr_i | input | 10 | Programmed own address (7-bit mode uses [6:0]) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| gc_en_i | input | 1 | 1 enables general-call recognition |
| buf_rd_i | input | 1 | Buffer read strobe, clears buffer-full |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| rx_byte_o | output | 8 | Last accepted byte |
| buf_full_o | output | 1 | Receive buffer holds an unread byte |
| irq_o | output | 1 | One-cycle pulse after each acknowledged byte |
| upd_addr_o | output | 1 | First 10-bit address half matched; low half expected |
| start_seen_o | output | 1 | Last bus condition was START |
| stop_seen_o | output | 1 | Last bus condition was STOP |
| bus_free_o | output | 1 | Bus free indication |

## Verification
The bench uses the default 8-bit byte width and sets the own address to 0x2A in 7-bit mode. It then sweeps all 256 first-byte values, once with general call enabled and once with it disabled. The expected acknowledge, buffer contents and interrupt count for each value follow from the match rule. Within that sweep every R/W variant of the own address is covered, along with the zero byte in both enable settings and the 10-bit prefix patterns seen in 7-bit mode. Directed sequences then use own address 0x2B5 to check the two-byte 10-bit match, a failing second half, the general-call shortcut in 10-bit mode, data after a match, and bytes clocked after STOP.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int OWN_W  = 10;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,   // waiting for START
    PH_ADDR1,  // first address byte
    PH_ADDR2,  // low half of a 10-bit address
    PH_DATA,   // matched, receiving bytes
    PH_SKIP    // not addressed, wait for START
  } phase_t;
endpackage

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_ev_o,
  output logic stop_ev_o
);
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      scl_p <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i;
      scl_p <= scl_q;
      sda_q <= sda_i;
      sda_p <= sda_q;
    end
  end

  assign scl_hi_o   = scl_q;
  assign sda_lvl_o  = sda_q;
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
  assign start_ev_o = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev_o  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cm_addr_cmp.sv
module i2cm_addr_cmp
  import i2cm_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [OWN_W-1:0]  own_addr_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  output logic              gc_hit_o,
  output logic              first_hit_o,
  output logic              low_hit_o
);
  logic hit7, hit10_hi;

  assign gc_hit_o    = gc_en_i & (byte_i == '0);
  assign hit7        = (byte_i[BYTE_W-1:1] == own_addr_i[BYTE_W-2:0]);
  assign hit10_hi    = (byte_i[BYTE_W-1:1] == {TEN_PREFIX, own_addr_i[OWN_W-1:BYTE_W]});
  assign first_hit_o = ten_bit_i ? hit10_hi : hit7;
  assign low_hit_o   = (byte_i == own_addr_i[BYTE_W-1:0]);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [OWN_W-1:0]  own_addr_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  input  logic              buf_rd_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              buf_full_o,
  output logic              irq_o,
  output logic              upd_addr_o,
  output logic              start_seen_o,
  output logic              stop_seen_o,
  output logic              bus_free_o
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic gc_hit, first_hit, low_hit;

  phase_t            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, buf_q, buf_n, byte_new;
  logic ack_q, ack_n, pend_q, pend_n, bf_q, bf_n, irq_q, irq_n;
  logic upd_q, upd_n, sta_q, sta_n, sto_q, sto_n;
  logic take;

  i2cm_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi_o(scl_hi), .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_ev_o(start_ev), .stop_ev_o(stop_ev)
  );

  assign byte_new = {sh_q[BYTE_W-2:0], sda_lvl};

  i2cm_addr_cmp u_cmp (
    .byte_i(byte_new), .own_addr_i(own_addr_i), .ten_bit_i(ten_bit_i),
    .gc_en_i(gc_en_i), .gc_hit_o(gc_hit), .first_hit_o(first_hit),
    .low_hit_o(low_hit)
  );

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    buf_n   = buf_q;
    ack_n   = ack_q;
    pend_n  = pend_q;
    bf_n    = bf_q & ~buf_rd_i;
    irq_n   = 1'b0;
    upd_n   = upd_q;
    sta_n   = sta_q;
    sto_n   = sto_q;
    take    = 1'b0;
    if (stop_ev) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      ack_n   = 1'b0;
      pend_n  = 1'b0;
      upd_n   = 1'b0;
      sto_n   = 1'b1;
      sta_n   = 1'b0;
    end else if (start_ev) begin
      phase_n = PH_ADDR1;
      cnt_n   = '0;
      ack_n   = 1'b0;
      pend_n  = 1'b0;
      upd_n   = 1'b0;
      sta_n   = 1'b1;
      sto_n   = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise) begin
        if (cnt_q < ACK_SLOT) begin
          sh_n  = byte_new;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            unique case (phase_q)
              PH_ADDR1: begin
                if (gc_hit) begin
                  take = 1'b1;
                  phase_n = PH_DATA;
                end else if (first_hit) begin
                  take = 1'b1;
                  phase_n = ten_bit_i ? PH_ADDR2 : PH_DATA;
                  upd_n = ten_bit_i;
                end else begin
                  phase_n = PH_SKIP;
                end
              end
              PH_ADDR2: begin
                upd_n   = 1'b0;
                take    = low_hit;
                phase_n = low_hit ? PH_DATA : PH_SKIP;
              end
              PH_DATA: take = 1'b1;
              default: take = 1'b0;
            endcase
          end
        end else if (cnt_q == ACK_SLOT) begin
          cnt_n = ACK_DONE;
        end
      end
      if (scl_fall) begin
        if (cnt_q == ACK_SLOT && pend_q) begin
          ack_n = 1'b1;
        end else if (cnt_q == ACK_DONE) begin
          ack_n  = 1'b0;
          irq_n  = pend_q;
          pend_n = 1'b0;
          cnt_n  = '0;
        end
      end
      if (take) begin
        buf_n  = byte_new;
        bf_n   = 1'b1;
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      buf_q   <= '0;
      ack_q   <= 1'b0;
      pend_q  <= 1'b0;
      bf_q    <= 1'b0;
      irq_q   <= 1'b0;
      upd_q   <= 1'b0;
      sta_q   <= 1'b0;
      sto_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      buf_q   <= buf_n;
      ack_q   <= ack_n;
      pend_q  <= pend_n;
      bf_q    <= bf_n;
      irq_q   <= irq_n;
      upd_q   <= upd_n;
      sta_q   <= sta_n;
      sto_q   <= sto_n;
    end
  end

  assign sda_pull_o   = ack_q;
  assign rx_byte_o    = buf_q;
  assign buf_full_o   = bf_q;
  assign irq_o        = irq_q;
  assign upd_addr_o   = upd_q;
  assign start_seen_o = sta_q;
  assign stop_seen_o  = sto_q;
  assign bus_free_o   = sto_q | ~(sta_q | sto_q);

  assert_ack_only_addressed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (phase_q == PH_ADDR2 || phase_q == PH_DATA));
  assert_irq_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !scl_hi);
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (phase_q == PH_IDLE && !sda_pull_o && !upd_addr_o));
  assert_upd_ten_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_addr_o |-> ten_bit_i);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen_o && stop_seen_o));
  assert_bf_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full_o) |-> $past(scl_rise));
endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [9:0] own = 10'h02A;
  logic ten = 1'b0, gce = 1'b0, brd = 1'b0;
  logic sda_pull, buf_full, irq, upd, sta, sto, bfree;
  logic [7:0] rxb;
  logic sda_bus;
  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .own_addr_i(own), .ten_bit_i(ten), .gc_en_i(gce), .buf_rd_i(brd),
    .sda_pull_o(sda_pull), .rx_byte_o(rxb), .buf_full_o(buf_full),
    .irq_o(irq), .upd_addr_o(upd), .start_seen_o(sta),
    .stop_seen_o(sto), .bus_free_o(bfree)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    m_sda = 1'b1; waitn(2); m_scl = 1'b1; waitn(4);
    m_sda = 1'b0; waitn(4); m_scl = 1'b0; waitn(2);
  endtask

  task automatic bstop();
    m_sda = 1'b0; waitn(2); m_scl = 1'b1; waitn(4);
    m_sda = 1'b1; waitn(4);
  endtask

  task automatic clear_buf();
    brd = 1'b1; waitn(1); brd = 1'b0; waitn(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output int irqs);
    int i0;
    i0 = irq_cnt;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitn(2); m_scl = 1'b1; waitn(4); m_scl = 1'b0; waitn(2);
    end
    m_sda = 1'b1; waitn(2); m_scl = 1'b1; waitn(2);
    ack = sda_pull;
    waitn(2); m_scl = 1'b0; waitn(6);
    irqs = irq_cnt - i0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    int q;
    logic exp;
    waitn(3); rst_n = 1'b1; waitn(2);
    // R1 reset state
    chk("R1 pull", sda_pull, 0); chk("R1 bf", buf_full, 0);
    chk("R1 irq", irq, 0); chk("R1 upd", upd, 0);
    chk("R1 start", sta, 0); chk("R1 stop", sto, 0); chk("R1 free", bfree, 1);

    // R2 condition flags
    bstart();
    chk("R2 start", sta, 1); chk("R2 stop", sto, 0); chk("R2 free", bfree, 0);
    bstop();
    chk("R2 stop set", sto, 1); chk("R2 start clr", sta, 0); chk("R2 free stop", bfree, 1);

    // R3 R5 R6 R4: sweep all first bytes, gc off/on
    for (int g = 0; g < 2; g++) begin
      gce = g[0];
      for (int b = 0; b < 256; b++) begin
        clear_buf();
        exp = (b[7:1] == own[6:0]) || (g == 1 && b == 0);
        bstart();
        send_byte(b[7:0], a, q);
        chk(exp ? "R3 ack" : "R5 noack", a, exp);
        chk(b == 0 ? "R6 gc irq" : "R4 irq", q, exp ? 1 : 0);
        chk("R3 bf", buf_full, exp);
        if (exp) chk("R3 buf", rxb, b);
        bstop();
      end
    end

    // R9 data after match, R11 read clears
    gce = 1'b0;
    clear_buf(); bstart();
    send_byte(8'h55, a, q); chk("R3 read addr ack", a, 1);
    clear_buf(); chk("R11 clr", buf_full, 0);
    send_byte(8'hC3, a, q);
    chk("R9 ack", a, 1); chk("R9 irq", q, 1); chk("R9 buf", rxb, 8'hC3); chk("R9 bf", buf_full, 1);
    bstop();
    // R5 data after mismatch ignored
    bstart(); send_byte(8'h56, a, q); chk("R5 addr", a, 0);
    send_byte(8'h00, a, q); chk("R5 data noack", a, 0); chk("R5 data irq", q, 0);
    bstop();

    // R7 10-bit match
    ten = 1'b1; own = 10'h2B5; gce = 1'b1;
    clear_buf(); bstart();
    send_byte(8'hF4, a, q); chk("R7 hi ack", a, 1); chk("R7 upd set", upd, 1); chk("R7 hi irq", q, 1);
    send_byte(8'hB5, a, q); chk("R7 lo ack", a, 1); chk("R7 upd clr", upd, 0); chk("R7 lo buf", rxb, 8'hB5);
    send_byte(8'h3C, a, q); chk("R7 data ack", a, 1); chk("R7 data buf", rxb, 8'h3C);
    bstop();
    // R7 wrong low half
    bstart();
    send_byte(8'hF4, a, q); chk("R7 hi2 ack", a, 1);
    send_byte(8'hB4, a, q); chk("R7 bad lo", a, 0); chk("R7 bad lo upd", upd, 0);
    send_byte(8'h3C, a, q); chk("R7 ignored", a, 0); chk("R7 ignored irq", q, 0);
    bstop();
    // R7 wrong upper bits
    bstart(); send_byte(8'hF2, a, q); chk("R7 bad hi", a, 0); chk("R7 bad hi upd", upd, 0);
    bstop();
    // R8 general call in 10-bit
    bstart();
    send_byte(8'h00, a, q); chk("R8 gc ack", a, 1); chk("R8 upd", upd, 0); chk("R8 gc buf", rxb, 0);
    send_byte(8'h77, a, q); chk("R8 data ack", a, 1); chk("R8 data buf", rxb, 8'h77);
    bstop();
    // R10 stop clears upd and ignores bytes without START
    bstart(); send_byte(8'hF4, a, q); chk("R10 pre upd", upd, 1);
    bstop(); chk("R10 upd clr", upd, 0);
    m_scl = 1'b0; waitn(2);
    send_byte(8'hB5, a, q); chk("R10 no ack", a, 0); chk("R10 no irq", q, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule